// File: doc/BRIEF.md
# AC'97 Register Readback Multiplexer

This block forms the read data returned over an AC'97 link for a register access. The register file is a small RAM outside the block. The RAM word at the link's read address arrives on `ram_rdata`, and for most registers the block registers that word unchanged. Some bits are replaced instead. The two identification registers take one bit from the address-select pin, and another of their bits is forced to zero. The power-control register shows a line-forcing bit that the block keeps itself.

That power bit is written through the link's write port. While it is set, `lines_hold_low` tells the link to drive its bit clock and its return serial data low. A warm reset clears the bit without any write, so the RAM copy can be stale, and the block's own copy is the one returned on reads. The address-select level is only ever merged into link reads. The DSP side of the RAM never sees it.

Top module: `ac97_rdmux`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rd_data` becomes 0000h and `lines_hold_low` becomes 0.
- R2: If `rd_en` is high at a clock edge and `rd_addr` is an even, implemented address, `rd_data` takes `ram_rdata` after that edge. The exceptions are R4, R5 and R8. By default the implemented addresses are 00h–3Eh, 5Ah, 7Ch and 7Eh.
- R3: A read of an odd address, or of an even address that is not implemented, returns 0000h.
- R4: On a read of 28h or 3Ch, bit 14 of `rd_data` carries the level of `sel_pin` at the clock edge.
- R5: On a read of 28h or 3Ch, bit 15 is 0, and bits 13..0 come from `ram_rdata`.
- R6: A write to 26h (`wr_en` high, `wr_addr`=26h) loads `wr_data[12]` into the power bit. `lines_hold_low` shows the power bit, so it changes one cycle after the write.
- R7: A `warm_rst` pulse clears the power bit on the next edge. This takes priority over a write to 26h in the same cycle.
- R8: On a read of 26h, bit 12 of `rd_data` is the power bit as it stood before the edge, and the other bits come from `ram_rdata`.
- R9: While `rd_en` is low, `rd_data` holds its value.
- R10: Writes to any address other than 26h leave the power bit, and so `lines_hold_low`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 7 | Link read address |
| ram_rdata | input | 16 | RAM word at `rd_addr` |
| sel_pin | input | 1 | Address-select pin level |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 7 | Write address |
| wr_data | input | 16 | Write data |
| warm_rst | input | 1 | Warm reset pulse |
| rd_data | output | 16 | Registered read data |
| lines_hold_low | output | 1 | Force bit clock and return data low |

## Verification
The case that is hardest to reach is a power bit that no longer matches the RAM. This happens when a warm reset lands on the same cycle as a write that sets the bit, and a read of 26h follows. Directed steps build that collision, and also a write to another address with bit 12 set. Random cycles then mix reads of 26h, 28h and 3Ch with random `sel_pin` levels, RAM words and rare warm resets.

// File: rtl/ac97_rd_pkg.sv
// Shared constants and the read-address decode helper for the readback
// multiplexer. Assumes 7-bit byte addresses of 16-bit registers.
package ac97_rd_pkg;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 16;
    localparam int NREGS   = 1 << (ADDR_W - 1);

    localparam logic [ADDR_W-1:0] PWR_ADDR  = 7'h26;
    localparam logic [ADDR_W-1:0] IDA_ADDR  = 7'h28;
    localparam logic [ADDR_W-1:0] IDB_ADDR  = 7'h3C;

    localparam int PWR_BIT  = 12;
    localparam int SEL_BIT  = 14;
    localparam int ZERO_BIT = 15;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_ID    = 2'd1,
        K_PWR   = 2'd2,
        K_NONE  = 2'd3
    } rd_kind_t;
endpackage

// File: rtl/ac97_addr_decode.sv
// Sorts a read address into a kind: plain RAM word, ID register, power
// register or absent. Assumes IMPL_MASK bit i stands for address 2*i.
module ac97_addr_decode
    import ac97_rd_pkg::*;
#(
    parameter logic [NREGS-1:0] IMPL_MASK = 64'hC000_2000_FFFF_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output rd_kind_t          kind
);
    // Classify the address combinationally.
    always_comb begin
        if (addr[0] || !IMPL_MASK[addr[ADDR_W-1:1]])
            kind = K_NONE;
        else if (addr == IDA_ADDR || addr == IDB_ADDR)
            kind = K_ID;
        else if (addr == PWR_ADDR)
            kind = K_PWR;
        else
            kind = K_PLAIN;
    end
endmodule

// File: rtl/ac97_pwr_hold.sv
// Keeps the line-forcing power bit. Writes to the power register load it.
// A warm reset clears it and wins over a write in the same cycle.
module ac97_pwr_hold
    import ac97_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic              warm_rst,
    output logic              pwr_q
);
    logic hit;
    assign hit = wr_en && (wr_addr == PWR_ADDR);

    // Update the held bit. Reset and warm reset take priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        pwr_q <= 1'b0;
        else if (warm_rst) pwr_q <= 1'b0;
        else if (hit)      pwr_q <= wr_bit;
    end

    a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PWR_ADDR && !warm_rst) |=> (pwr_q == $past(wr_bit)));
    a_r7_warm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> !pwr_q);
    a_r10_other_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm_rst && !(wr_en && wr_addr == PWR_ADDR)) |=> $stable(pwr_q));
endmodule

// File: rtl/ac97_rd_merge.sv
// Merges the RAM word with the pin and power overrides and registers the
// result. Assumes sel_pin is already synchronous to clk.
module ac97_rd_merge
    import ac97_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  rd_kind_t          kind,
    input  logic [DATA_W-1:0] ram_word,
    input  logic              sel_pin,
    input  logic              pwr_q,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] merged;

    // Apply the per-kind overrides to the RAM word.
    always_comb begin
        merged = ram_word;
        unique case (kind)
            K_ID: begin
                merged[SEL_BIT]  = sel_pin;
                merged[ZERO_BIT] = 1'b0;
            end
            K_PWR:  merged[PWR_BIT] = pwr_q;
            K_NONE: merged = '0;
            default: ;
        endcase
    end

    // Register the read data when it is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= merged;
    end

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_q));
    a_r3_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == K_NONE) |=> (rd_q == '0));
    a_r5_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == K_ID) |=> !rd_q[ZERO_BIT]);
    a_r4_pin_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == K_ID) |=> (rd_q[SEL_BIT] == $past(sel_pin)));
endmodule

// File: rtl/ac97_rdmux.sv
// Top of the readback multiplexer. It decodes the read address, keeps the
// power bit and registers the merged read word. Assumes the RAM word at
// rd_addr is valid in the same cycle.
module ac97_rdmux
    import ac97_rd_pkg::*;
#(
    parameter logic [NREGS-1:0] IMPL_MASK = 64'hC000_2000_FFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              sel_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              warm_rst,
    output logic [DATA_W-1:0] rd_data,
    output logic              lines_hold_low
);
    rd_kind_t kind;
    logic     pwr_q;
    logic     unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[DATA_W-1:PWR_BIT+1], wr_data[PWR_BIT-1:0]};

    ac97_addr_decode #(.IMPL_MASK(IMPL_MASK)) u_dec (
        .addr (rd_addr),
        .kind (kind)
    );

    ac97_pwr_hold u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_bit   (wr_data[PWR_BIT]),
        .warm_rst (warm_rst),
        .pwr_q    (pwr_q)
    );

    ac97_rd_merge u_mrg (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .kind     (kind),
        .ram_word (ram_rdata),
        .sel_pin  (sel_pin),
        .pwr_q    (pwr_q),
        .rd_q     (rd_data)
    );

    assign lines_hold_low = pwr_q;

    a_r8_pwr_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == PWR_ADDR) |=> (rd_data[PWR_BIT] == $past(lines_hold_low)));
    a_r2_plain_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == K_PLAIN) |=> (rd_data == $past(ram_rdata)));
endmodule

// File: tb/sim_ac97_rdmux.sv
// Bench for ac97_rdmux: directed corner cases followed by seeded random cycles.
module sim_ac97_rdmux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] ram_rdata = '0;
    logic        sel_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        warm_rst = 1'b0;
    logic [15:0] rd_data;
    logic        lines_hold_low;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic        m_pwr = 1'b0;
    logic [15:0] m_rd = '0;

    always #2 clk = ~clk;

    ac97_rdmux u0 (.*);

    function automatic bit impl(input logic [6:0] a);
        return !a[0] && (a <= 7'h3E || a == 7'h5A || a >= 7'h7C);
    endfunction

    function automatic logic [15:0] expect_rd(input logic [6:0] a, input logic [15:0] w,
                                              input logic s, input logic p);
        logic [15:0] r;
        if (!impl(a)) return 16'h0000;
        r = w;
        if (a == 7'h28 || a == 7'h3C) begin r[14] = s; r[15] = 1'b0; end
        if (a == 7'h26) r[12] = p;
        return r;
    endfunction

    function automatic string tag_of(input logic [6:0] a, input logic re);
        if (!re) return "R9";
        if (!impl(a)) return "R3";
        if (a == 7'h28 || a == 7'h3C) return "R4/R5";
        if (a == 7'h26) return "R8";
        return "R2";
    endfunction

    task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: lines_hold_low=%b expected %b", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compute the model, check after the rising edge.
    task automatic cyc(input logic re, input logic [6:0] ra, input logic [15:0] rw,
                       input logic s, input logic we, input logic [6:0] wa,
                       input logic [15:0] wd, input logic wr, input string ptag);
        string t;
        rd_en = re; rd_addr = ra; ram_rdata = rw; sel_pin = s;
        wr_en = we; wr_addr = wa; wr_data = wd; warm_rst = wr;
        t = tag_of(ra, re);
        if (re) m_rd = expect_rd(ra, rw, s, m_pwr);
        if (wr) m_pwr = 1'b0;
        else if (we && wa == 7'h26) m_pwr = wd[12];
        @(posedge clk);
        @(negedge clk);
        chk16(t, rd_data, m_rd);
        chk1(ptag, lines_hold_low, m_pwr);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk16("R1", rd_data, 16'h0000);
        chk1("R1", lines_hold_low, 1'b0);
        rst_n = 1'b1;

        cyc(1, 7'h10, 16'hA5C3, 0, 0, 0, 0, 0, "R10");                // R2 plain read
        cyc(1, 7'h11, 16'hFFFF, 1, 0, 0, 0, 0, "R10");                // R3 odd address
        cyc(1, 7'h40, 16'hFFFF, 1, 0, 0, 0, 0, "R10");                // R3 unimplemented
        cyc(1, 7'h5A, 16'h1234, 0, 0, 0, 0, 0, "R10");                // R2 implemented high address
        cyc(1, 7'h28, 16'hFFFF, 0, 0, 0, 0, 0, "R10");                // R4 pin low, R5 bit 15 zero
        cyc(1, 7'h3C, 16'h0000, 1, 0, 0, 0, 0, "R10");                // R4 pin high
        cyc(1, 7'h20, 16'h0000, 0, 1, 7'h24, 16'h1000, 0, "R10");     // R10 other address
        cyc(1, 7'h26, 16'h0000, 0, 1, 7'h26, 16'h1000, 0, "R6");      // R6 set
        cyc(1, 7'h26, 16'h0000, 0, 0, 0, 0, 0, "R6");                 // R8 bit reads back 1
        cyc(0, 7'h10, 16'hBEEF, 0, 0, 0, 0, 1, "R7");                 // R9 hold, R7 clear
        cyc(1, 7'h26, 16'hFFFF, 0, 1, 7'h26, 16'h1000, 1, "R7");      // R7 priority over write
        cyc(1, 7'h26, 16'hFFFF, 0, 0, 0, 0, 0, "R7");                 // R8 RAM stale, bit reads 0
        cyc(1, 7'h26, 16'h0000, 0, 1, 7'h26, 16'h1000, 0, "R6");
        cyc(1, 7'h26, 16'h0000, 0, 1, 7'h26, 16'hEFFF, 0, "R6");      // R6 clear by write

        void'($urandom(32'd20240611));
        for (int i = 0; i < 600; i++) begin
            logic [6:0] ra;
            logic [6:0] wa;
            int pick;
            pick = $urandom_range(0, 5);
            case (pick)
                0: ra = 7'h26;
                1: ra = 7'h28;
                2: ra = 7'h3C;
                default: ra = 7'($urandom);
            endcase
            wa = ($urandom_range(0, 2) == 0) ? 7'h26 : 7'($urandom);
            cyc(($urandom_range(0, 4) != 0), ra, 16'($urandom), 1'($urandom),
                1'($urandom), wa, 16'($urandom), ($urandom_range(0, 15) == 0),
                "R6/R7/R10");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule